// File: doc/BRIEF.md
# Queued Conversion Command Sequencer

This block walks a 64-entry table of conversion command words and feeds a single shared converter. The table holds two queues. Queue 1 starts at entry 0. Queue 2 starts at a begin index supplied on an input, and queue 1 ends just before that index. Each queue has its own trigger input, its own command pointer and its own state.

A command word has a pause bit, which splits a queue into subqueues that each need a fresh trigger. It also has a channel field, and an all-ones channel value marks the end of the queue. Every finished conversion is written to the result table at the index of the command word that requested it.

When both queues have work, queue 1 always gets the converter first. A queue 2 conversion that has already started is never aborted. Each queue has sticky pause, completion and overrun flags. Each flag can raise an interrupt when its enable is set.

Top module: `qcmd_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, both queue states read idle (0), every flag and interrupt output is 0, and `conv_start_o` and `res_we_o` are 0.
- R2: A command word is `{pause, channel}`: bit 6 is the pause bit and bits 5:0 are the channel. When an idle queue is triggered, its state reads pending (1) on the next cycle and `conv_start_o` pulses one cycle later. The pulse carries the channel of the queue's first entry: entry 0 for queue 1, the begin index for queue 2.
- R3: Each completed conversion causes one `res_we_o` pulse. The pulse carries the command word's table index on `res_addr_o` and the converter result on `res_data_o`.
- R4: After the conversion of a word whose pause bit is set, the queue enters paused (3) and sets its pause flag. The pause interrupt equals the flag gated by its enable.
- R5: A trigger on a paused queue resumes it at the entry that follows the paused word.
- R6: A trigger on a pending (1) or active (2) queue does not change its execution. It sets that queue's overrun flag.
- R7: A queue completes (state 4) when one of these happens: its next word has channel 63, queue 1 reaches the begin index, or queue 2 passes entry 63. Completing sets the completion flag and raises the completion interrupt when that interrupt is enabled. A channel-63 word produces no conversion and no result write.
- R8: A trigger on a completed queue restarts it from its first entry when its continuous-scan input is 1. The trigger is ignored when that input is 0.
- R9: When both queues have pending work, queue 1 conversions are issued first. A queue 2 conversion already started finishes before queue 1 gets the converter.
- R10: At most one conversion is outstanding at a time, and `conv_start_o` is a one-cycle pulse.
- R11: Asserting a queue's bit of `flag_clr_i` clears its three flags on the next cycle, unless a flag is set by an event in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| q2_begin_i | input | 6 | First table entry of queue 2 |
| cont_i | input | 2 | Continuous-scan select per queue (bit 0 = queue 1) |
| trig_i | input | 2 | Trigger per queue |
| flag_clr_i | input | 2 | Flag clear per queue |
| pause_ie_i | input | 2 | Pause interrupt enable per queue |
| cmpl_ie_i | input | 2 | Completion interrupt enable per queue |
| tbl_addr_o | output | 6 | Command table read index |
| tbl_data_i | input | 7 | Command word at `tbl_addr_o` (same cycle) |
| conv_start_o | output | 1 | Start pulse to the converter |
| conv_chan_o | output | 6 | Channel for the started conversion |
| conv_done_i | input | 1 | Converter finished |
| conv_result_i | input | 10 | Converter result |
| res_we_o | output | 1 | Result table write strobe |
| res_addr_o | output | 6 | Result table index |
| res_data_o | output | 10 | Result value |
| q1_state_o | output | 3 | Queue 1 state |
| q2_state_o | output | 3 | Queue 2 state |
| pause_flag_o | output | 2 | Pause flags |
| cmpl_flag_o | output | 2 | Completion flags |
| ovr_flag_o | output | 2 | Trigger overrun flags |
| pause_irq_o | output | 2 | Pause interrupt requests |
| cmpl_irq_o | output | 2 | Completion interrupt requests |

## Verification
The assertions check several properties on every cycle:
- The converter handshake is never overlapped.
- Every start pulse lasts one cycle.
- Every result write answers an outstanding conversion.
- A pause or completion flag only rises as its queue enters the matching state.
- An overrun flag only rises after a trigger.

Other behaviour needs the bench's scenarios:
- The order of issued entries under contention between the queues.
- Resumption after a pause.
- Restart in continuous scan versus the ignored trigger in single scan.
- The queue 1 boundary at the begin index.
- Result data landing at the right index.

// File: rtl/qcmd_pkg.sv
package qcmd_pkg;
  typedef enum logic [2:0] {
    QS_IDLE   = 3'd0,
    QS_PEND   = 3'd1,
    QS_ACTIVE = 3'd2,
    QS_PAUSED = 3'd3,
    QS_DONE   = 3'd4
  } qstate_e;
endpackage

// File: rtl/qcmd_queue.sv
module qcmd_queue
  import qcmd_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] base_i,
  input  logic [IDX_W:0]   limit_i,
  input  logic             cont_i,
  input  logic             trig_i,
  input  logic             clr_i,
  input  logic             pause_ie_i,
  input  logic             cmpl_ie_i,
  input  logic             issue_i,
  input  logic             end_i,
  input  logic             retire_i,
  input  logic             retire_pause_i,
  output logic             want_o,
  output logic             at_end_o,
  output logic [IDX_W-1:0] ptr_o,
  output qstate_e          state_o,
  output logic             pause_flag_o,
  output logic             cmpl_flag_o,
  output logic             ovr_flag_o,
  output logic             pause_irq_o,
  output logic             cmpl_irq_o
);
  qstate_e          state_q;
  logic [IDX_W:0]   ptr_q;
  logic             pause_q, cmpl_q, ovr_q;

  assign want_o       = (state_q == QS_PEND) || (state_q == QS_ACTIVE);
  assign at_end_o     = ptr_q >= limit_i;
  assign ptr_o        = ptr_q[IDX_W-1:0];
  assign state_o      = state_q;
  assign pause_flag_o = pause_q;
  assign cmpl_flag_o  = cmpl_q;
  assign ovr_flag_o   = ovr_q;
  assign pause_irq_o  = pause_q & pause_ie_i;
  assign cmpl_irq_o   = cmpl_q & cmpl_ie_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= QS_IDLE;
      ptr_q   <= '0;
      pause_q <= 1'b0;
      cmpl_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (clr_i) begin
        pause_q <= 1'b0;
        cmpl_q  <= 1'b0;
        ovr_q   <= 1'b0;
      end
      unique case (state_q)
        QS_IDLE: if (trig_i) begin
          state_q <= QS_PEND;
          ptr_q   <= {1'b0, base_i};
        end
        QS_PEND, QS_ACTIVE: begin
          if (trig_i) ovr_q <= 1'b1;   // running subqueue: trigger only flagged
          if (issue_i) begin
            state_q <= QS_ACTIVE;
            ptr_q   <= ptr_q + 1'b1;
          end else if (end_i) begin
            state_q <= QS_DONE;
            cmpl_q  <= 1'b1;
          end else if (retire_i && retire_pause_i) begin
            state_q <= QS_PAUSED;
            pause_q <= 1'b1;
          end
        end
        QS_PAUSED: if (trig_i) state_q <= QS_PEND;
        QS_DONE: if (trig_i && cont_i) begin
          state_q <= QS_PEND;
          ptr_q   <= {1'b0, base_i};
        end
        default: state_q <= QS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/qcmd_arb.sv
module qcmd_arb (
  input  logic [1:0] want_i,
  input  logic       busy_i,
  output logic       go_o,
  output logic       sel_o
);
  // fixed priority: queue 1 (bit 0) wins; no preemption while busy
  assign go_o  = !busy_i && (|want_i);
  assign sel_o = !want_i[0];
endmodule

// File: rtl/qcmd_seq.sv
module qcmd_seq
  import qcmd_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int CH_W  = 6,
  parameter int RES_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] q2_begin_i,
  input  logic [1:0]       cont_i,
  input  logic [1:0]       trig_i,
  input  logic [1:0]       flag_clr_i,
  input  logic [1:0]       pause_ie_i,
  input  logic [1:0]       cmpl_ie_i,
  output logic [IDX_W-1:0] tbl_addr_o,
  input  logic [CH_W:0]    tbl_data_i,
  output logic             conv_start_o,
  output logic [CH_W-1:0]  conv_chan_o,
  input  logic             conv_done_i,
  input  logic [RES_W-1:0] conv_result_i,
  output logic             res_we_o,
  output logic [IDX_W-1:0] res_addr_o,
  output logic [RES_W-1:0] res_data_o,
  output logic [2:0]       q1_state_o,
  output logic [2:0]       q2_state_o,
  output logic [1:0]       pause_flag_o,
  output logic [1:0]       cmpl_flag_o,
  output logic [1:0]       ovr_flag_o,
  output logic [1:0]       pause_irq_o,
  output logic [1:0]       cmpl_irq_o
);
  localparam int NQ = 2;
  localparam logic [IDX_W:0]  END_IDX = {1'b1, {IDX_W{1'b0}}};
  localparam logic [CH_W-1:0] EOQ_CH  = '1;

  logic [NQ-1:0]    want, at_end, issue_v, end_v, retire_v;
  logic [IDX_W-1:0] qptr [NQ];
  qstate_e          qst  [NQ];
  logic             go, sel, stop, issue;
  logic             busy_q, own_q, pause_q;
  logic [IDX_W-1:0] idx_q;
  logic [CH_W-1:0]  cmd_chan;
  logic             cmd_pause;

  qcmd_arb u_arb (
    .want_i (want),
    .busy_i (busy_q),
    .go_o   (go),
    .sel_o  (sel)
  );

  assign tbl_addr_o = qptr[sel];
  assign cmd_chan   = tbl_data_i[CH_W-1:0];
  assign cmd_pause  = tbl_data_i[CH_W];
  assign stop       = go && (at_end[sel] || (cmd_chan == EOQ_CH));
  assign issue      = go && !stop;

  for (genvar g = 0; g < NQ; g++) begin : g_q
    assign issue_v[g]  = issue && (sel == 1'(g));
    assign end_v[g]    = stop && (sel == 1'(g));
    assign retire_v[g] = busy_q && conv_done_i && (own_q == 1'(g));

    qcmd_queue #(.IDX_W(IDX_W)) u_queue (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .base_i         ((g == 0) ? '0 : q2_begin_i),
      .limit_i        ((g == 0) ? {1'b0, q2_begin_i} : END_IDX),
      .cont_i         (cont_i[g]),
      .trig_i         (trig_i[g]),
      .clr_i          (flag_clr_i[g]),
      .pause_ie_i     (pause_ie_i[g]),
      .cmpl_ie_i      (cmpl_ie_i[g]),
      .issue_i        (issue_v[g]),
      .end_i          (end_v[g]),
      .retire_i       (retire_v[g]),
      .retire_pause_i (pause_q),
      .want_o         (want[g]),
      .at_end_o       (at_end[g]),
      .ptr_o          (qptr[g]),
      .state_o        (qst[g]),
      .pause_flag_o   (pause_flag_o[g]),
      .cmpl_flag_o    (cmpl_flag_o[g]),
      .ovr_flag_o     (ovr_flag_o[g]),
      .pause_irq_o    (pause_irq_o[g]),
      .cmpl_irq_o     (cmpl_irq_o[g])
    );
  end

  assign q1_state_o = qst[0];
  assign q2_state_o = qst[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q       <= 1'b0;
      own_q        <= 1'b0;
      pause_q      <= 1'b0;
      idx_q        <= '0;
      conv_start_o <= 1'b0;
      conv_chan_o  <= '0;
      res_we_o     <= 1'b0;
      res_addr_o   <= '0;
      res_data_o   <= '0;
    end else begin
      conv_start_o <= issue;
      res_we_o     <= busy_q && conv_done_i;
      if (issue) begin
        busy_q      <= 1'b1;
        own_q       <= sel;
        idx_q       <= tbl_addr_o;
        pause_q     <= cmd_pause;
        conv_chan_o <= cmd_chan;
      end
      if (busy_q && conv_done_i) begin
        busy_q     <= 1'b0;
        res_addr_o <= idx_q;
        res_data_o <= conv_result_i;
      end
    end
  end
endmodule

// File: rtl/qcmd_seq_chk.sv
module qcmd_seq_chk
  import qcmd_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] trig_i,
  input logic       conv_start_o,
  input logic       res_we_o,
  input logic [2:0] q1_state_o,
  input logic [2:0] q2_state_o,
  input logic [1:0] pause_flag_o,
  input logic [1:0] cmpl_flag_o,
  input logic [1:0] ovr_flag_o
);
  logic outst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           outst_q <= 1'b0;
    else if (conv_start_o) outst_q <= 1'b1;
    else if (res_we_o)     outst_q <= 1'b0;
  end

  // R10
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);
  // R10
  single_outst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> !outst_q);
  // R3
  write_has_conv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_we_o |-> outst_q);
  // R4
  q1_pause_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pause_flag_o[0]) |-> (q1_state_o == QS_PAUSED));
  // R4
  q2_pause_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pause_flag_o[1]) |-> (q2_state_o == QS_PAUSED));
  // R7
  q1_cmpl_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmpl_flag_o[0]) |-> (q1_state_o == QS_DONE));
  // R7
  q2_cmpl_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmpl_flag_o[1]) |-> (q2_state_o == QS_DONE));
  // R6
  q1_ovr_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_flag_o[0]) |-> $past(trig_i[0]));
  // R6
  q2_ovr_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_flag_o[1]) |-> $past(trig_i[1]));
endmodule

bind qcmd_seq qcmd_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .trig_i       (trig_i),
  .conv_start_o (conv_start_o),
  .res_we_o     (res_we_o),
  .q1_state_o   (q1_state_o),
  .q2_state_o   (q2_state_o),
  .pause_flag_o (pause_flag_o),
  .cmpl_flag_o  (cmpl_flag_o),
  .ovr_flag_o   (ovr_flag_o)
);

// File: tb/qcmd_seq_bench.sv
module qcmd_seq_bench;
  localparam int IDX_W = 6, CH_W = 6, RES_W = 10, DEPTH = 64, LAT = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic [IDX_W-1:0] q2_begin = 6'd8;
  logic [1:0] cont = 2'b00, trig = 2'b00, flag_clr = 2'b00;
  logic [1:0] pause_ie = 2'b10, cmpl_ie = 2'b01;
  logic [IDX_W-1:0] tbl_addr, res_addr;
  logic [CH_W:0] tbl [DEPTH];
  logic [CH_W:0] tbl_data;
  logic conv_start, conv_done = 1'b0, res_we;
  logic [CH_W-1:0] conv_chan, cnv_ch;
  logic [RES_W-1:0] conv_result = '0, res_data;
  logic [2:0] q1_st, q2_st;
  logic [1:0] pflag, cflag, oflag, pirq, cirq;

  assign tbl_data = tbl[tbl_addr];

  qcmd_seq u_qcmd_seq (
    .clk_i(clk), .rst_ni(rst_ni), .q2_begin_i(q2_begin), .cont_i(cont),
    .trig_i(trig), .flag_clr_i(flag_clr), .pause_ie_i(pause_ie), .cmpl_ie_i(cmpl_ie),
    .tbl_addr_o(tbl_addr), .tbl_data_i(tbl_data), .conv_start_o(conv_start),
    .conv_chan_o(conv_chan), .conv_done_i(conv_done), .conv_result_i(conv_result),
    .res_we_o(res_we), .res_addr_o(res_addr), .res_data_o(res_data),
    .q1_state_o(q1_st), .q2_state_o(q2_st), .pause_flag_o(pflag),
    .cmpl_flag_o(cflag), .ovr_flag_o(oflag), .pause_irq_o(pirq), .cmpl_irq_o(cirq)
  );

  // converter model: result = {channel, 4'h5}, done LAT negedges after start seen
  int cnv_cnt = 0;
  always @(negedge clk) begin
    conv_done = 1'b0;
    if (cnv_cnt > 0) begin
      cnv_cnt--;
      if (cnv_cnt == 0) begin
        conv_done   = 1'b1;
        conv_result = {cnv_ch, 4'h5};
      end
    end else if (conv_start) begin
      cnv_cnt = LAT;
      cnv_ch  = conv_chan;
    end
  end

  logic [RES_W-1:0] rmem [DEPTH];
  int rlog [16];
  int rcnt = 0;
  always @(negedge clk) if (res_we) begin
    rmem[res_addr] = res_data;
    if (rcnt < 16) rlog[rcnt] = int'(res_addr);
    rcnt++;
  end

  int n_run = 0, n_fail = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    trig = 2'b00;
    flag_clr = 2'b00;
    repeat (3) @(negedge clk);
    for (int i = 0; i < DEPTH; i++) rmem[i] = '1;
    for (int i = 0; i < 16; i++) rlog[i] = -1;
    rcnt = 0;
    cnv_cnt = 0;
    rst_ni = 1'b1;
  endtask

  task automatic pulse(input logic [1:0] m);
    @(negedge clk) trig = m;
    @(negedge clk) trig = 2'b00;
  endtask

  // {trig[1:0], q1 state[2:0], q2 state[2:0], result count[7:0]}
  localparam logic [15:0] VEC [5] = '{
    {2'b01, 3'd3, 3'd0, 8'd3},   // R2 R4: q1 runs 0..2, pauses
    {2'b01, 3'd4, 3'd0, 8'd5},   // R5 R7: resumes at 3, hits marker at 5
    {2'b10, 3'd4, 3'd3, 8'd7},   // R2 R4: q2 runs 8,9, pauses
    {2'b10, 3'd4, 3'd4, 8'd8},   // R5 R7: 10, marker at 11
    {2'b01, 3'd4, 3'd4, 8'd8}    // R8: single-scan trigger on done ignored
  };

  initial begin
    for (int i = 0; i < DEPTH; i++) tbl[i] = {1'b0, 6'd20};
    tbl[0] = {1'b0, 6'd1};  tbl[1] = {1'b0, 6'd2};  tbl[2] = {1'b1, 6'd3};
    tbl[3] = {1'b0, 6'd4};  tbl[4] = {1'b0, 6'd5};  tbl[5] = {1'b0, 6'd63};
    tbl[8] = {1'b0, 6'd10}; tbl[9] = {1'b1, 6'd11}; tbl[10] = {1'b0, 6'd12};
    tbl[11] = {1'b0, 6'd63};

    do_reset();
    // R1 reset state
    chk("R1 q1 state", int'(q1_st), 0);
    chk("R1 q2 state", int'(q2_st), 0);
    chk("R1 flags", int'({pflag, cflag, oflag, pirq, cirq}), 0);
    chk("R1 start/we", int'({conv_start, res_we}), 0);

    foreach (VEC[v]) begin
      pulse(VEC[v][15:14]);
      repeat (40) @(negedge clk);
      chk("R4/R5/R7/R8 q1 state", int'(q1_st), int'(VEC[v][13:11]));
      chk("R4/R5/R7/R8 q2 state", int'(q2_st), int'(VEC[v][10:8]));
      chk("R3/R7/R8 result count", rcnt, int'(VEC[v][7:0]));
    end
    chk("R3 data at 2", int'(rmem[2]), int'({6'd3, 4'h5}));
    chk("R3 data at 10", int'(rmem[10]), int'({6'd12, 4'h5}));
    chk("R7 marker not written", int'(rmem[5]), 1023);
    chk("R5 order after pause", rlog[3], 3);
    chk("R4 pause irq gated", int'(pirq), 2);
    chk("R7 cmpl irq gated", int'(cirq), 1);
    chk("R6 no overrun yet", int'(oflag), 0);

    // R11 clear flags
    @(negedge clk) flag_clr = 2'b11;
    @(negedge clk) flag_clr = 2'b00;
    chk("R11 flags cleared", int'({pflag, cflag, oflag}), 0);

    // R8 continuous restart, R6 overrun
    cont = 2'b01;
    pulse(2'b01);
    repeat (2) @(negedge clk);
    pulse(2'b01);
    repeat (40) @(negedge clk);
    chk("R8 restart from entry 0", rlog[8], 0);
    chk("R6 overrun flag", int'(oflag), 1);
    chk("R6 execution unchanged", int'(q1_st), 3);
    chk("R6 count after restart", rcnt, 11);
    cont = 2'b00;

    // R2 exact start timing
    do_reset();
    @(negedge clk) trig = 2'b01;
    @(negedge clk) trig = 2'b00;
    chk("R2 pending state", int'(q1_st), 1);
    chk("R2 no start yet", int'(conv_start), 0);
    @(negedge clk);
    chk("R2 start pulse", int'(conv_start), 1);
    chk("R2 first channel", int'(conv_chan), 1);
    @(negedge clk);
    chk("R10 pulse one cycle", int'(conv_start), 0);
    repeat (40) @(negedge clk);

    // R9 both triggered together
    do_reset();
    pulse(2'b11);
    repeat (60) @(negedge clk);
    chk("R9 q1 first", rlog[0], 0);
    chk("R9 q1 before q2", rlog[2], 2);
    chk("R9 q2 after q1 pause", rlog[3], 8);
    chk("R9 q2 continues", rlog[4], 9);

    // R9 no preemption of a started q2 conversion
    do_reset();
    pulse(2'b10);
    pulse(2'b01);
    repeat (60) @(negedge clk);
    chk("R9 q2 conversion kept", rlog[0], 8);
    chk("R9 q1 takes over", rlog[1], 0);

    // R7 queue 1 boundary at begin index
    do_reset();
    q2_begin = 6'd3;
    pulse(2'b01);
    repeat (40) @(negedge clk);
    pulse(2'b01);
    repeat (20) @(negedge clk);
    chk("R7 boundary state", int'(q1_st), 4);
    chk("R7 boundary no write", rcnt, 3);
    chk("R7 boundary cmpl flag", int'(cflag), 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule